// File: doc/BRIEF.md
# GPIO Interrupt Detection Controller

This block watches a bank of general-purpose input lines and raises one combined interrupt when any line that software has not masked has something pending. Each line has its own choice of sensitivity: level, or edge. A polarity bit picks the active level or edge direction. In edge mode, a both-edges bit makes the line fire on either transition whatever its polarity bit says. Edge events are held in a sticky pending bit until software writes a 1 to that bit. A level line reports its input condition directly, for as long as the condition holds.

Software reaches the block through a simple single-cycle register port. Writes take effect on the clock edge. A read returns its data one cycle after the request, together with a valid strobe. The mask is changed only through two strobe registers. Writing 1s to the set register masks lines, and writing 1s to the clear register unmasks them. The block also holds per-line bypass, direction and output-enable bits and drives them out to the pad logic. An interrupt line is used with bypass off, direction input and output disabled.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the mask is all ones, all other configuration registers read zero, status reads zero and `irq_o` is low.
- R2: A write to the mask-set register (address 3) masks every line whose data bit is 1. Lines whose data bit is 0 keep their mask state. Reading address 3 or 4 returns the mask, with 1 meaning masked.
- R3: A write to the mask-clear register (address 4) unmasks every line whose data bit is 1. Lines whose data bit is 0 keep their mask state.
- R4: A line in edge mode (type bit 0 at address 0) with its both-edges bit clear (address 2) marks itself pending on a rising edge when its polarity bit (address 1) is 1, and on a falling edge when that bit is 0. An edge of the other direction has no effect.
- R5: When the both-edges bit is set, an edge-mode line marks itself pending on both rising and falling edges, whatever its polarity bit holds.
- R6: A line in level mode (type bit 1) reads pending in status (address 5) exactly while its synchronised input equals its polarity bit. Writing 1 to its status bit does not change it.
- R7: An edge pending bit stays set until a write to address 5 carries a 1 in that bit. A 0 in the written data leaves the bit unchanged.
- R8: `irq_o` is high one cycle after any line is both pending and unmasked. A masked line still shows as pending in status but does not raise `irq_o`.
- R9: The bypass, direction and output-enable registers (addresses 7, 8 and 9) read back what was written and drive `cfg_bypass_o`, `cfg_dir_o` and `cfg_oe_o`.
- R10: Each input passes through two flops before any use. Address 6 returns the synchronised inputs, so a pin change is not yet visible to a read requested in the same cycle as the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | 16 | Asynchronous GPIO input lines |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_re |
| irq_o | output | 1 | Combined registered interrupt |
| cfg_bypass_o | output | 16 | Per-line bypass configuration |
| cfg_dir_o | output | 16 | Per-line direction configuration |
| cfg_oe_o | output | 16 | Per-line output-enable configuration |

## Verification
A corrupted mask bit shows at `irq_o` on the next cycle that line becomes pending. It also shows on the next read of address 3 or 4. A lost or stuck edge pending bit shows at the status read that follows the edge by a few cycles. It also shows as an `irq_o` that never clears after the write-one-to-clear. A wrong edge history or polarity choice shows as a status bit that sets on the wrong transition. A missing synchroniser stage shows as pin data returned one cycle early.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    A_LEVEL  = 4'd0,
    A_POL    = 4'd1,
    A_ANY    = 4'd2,
    A_MSET   = 4'd3,
    A_MCLR   = 4'd4,
    A_STAT   = 4'd5,
    A_PIN    = 4'd6,
    A_BYPASS = 4'd7,
    A_DIR    = 4'd8,
    A_OE     = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic lvl_mode,
  input  logic pol,
  input  logic any_edge,
  input  logic clr,
  output logic pend_o,
  output logic status_o
);
  logic prev_q;
  logic rise, fall, hit, lvl_hit;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= pin_s;
  end

  assign rise    = pin_s & ~prev_q;
  assign fall    = ~pin_s & prev_q;
  assign hit     = ~lvl_mode & (any_edge ? (rise | fall) : (pol ? rise : fall));
  assign lvl_hit = pol ? pin_s : ~pin_s;

  always_ff @(posedge clk) begin
    if (rst)      pend_o <= 1'b0;
    else if (hit) pend_o <= 1'b1;
    else if (clr) pend_o <= 1'b0;
  end

  assign status_o = lvl_mode ? lvl_hit : pend_o;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int N_LINES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic               re,
  input  logic [REG_AW-1:0]  addr,
  input  logic [N_LINES-1:0] wdata,
  input  logic [N_LINES-1:0] status,
  input  logic [N_LINES-1:0] pin_s,
  output logic [N_LINES-1:0] lvl_q,
  output logic [N_LINES-1:0] pol_q,
  output logic [N_LINES-1:0] any_q,
  output logic [N_LINES-1:0] mask_q,
  output logic [N_LINES-1:0] byp_q,
  output logic [N_LINES-1:0] dir_q,
  output logic [N_LINES-1:0] oe_q,
  output logic [N_LINES-1:0] stat_clr,
  output logic [N_LINES-1:0] rdata,
  output logic               rvalid
);
  logic [N_LINES-1:0] rd_mux;

  assign stat_clr = (we && addr == A_STAT) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= '0;
      pol_q  <= '0;
      any_q  <= '0;
      byp_q  <= '0;
      dir_q  <= '0;
      oe_q   <= '0;
      mask_q <= '1;
    end else if (we) begin
      case (addr)
        A_LEVEL:  lvl_q  <= wdata;
        A_POL:    pol_q  <= wdata;
        A_ANY:    any_q  <= wdata;
        A_MSET:   mask_q <= mask_q | wdata;
        A_MCLR:   mask_q <= mask_q & ~wdata;
        A_BYPASS: byp_q  <= wdata;
        A_DIR:    dir_q  <= wdata;
        A_OE:     oe_q   <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_LEVEL:        rd_mux = lvl_q;
      A_POL:          rd_mux = pol_q;
      A_ANY:          rd_mux = any_q;
      A_MSET, A_MCLR: rd_mux = mask_q;
      A_STAT:         rd_mux = status;
      A_PIN:          rd_mux = pin_s;
      A_BYPASS:       rd_mux = byp_q;
      A_DIR:          rd_mux = dir_q;
      A_OE:           rd_mux = oe_q;
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
      if (re) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int N_LINES     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] pin_i,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic [N_LINES-1:0] bus_wdata,
  output logic [N_LINES-1:0] bus_rdata,
  output logic               bus_rvalid,
  output logic               irq_o,
  output logic [N_LINES-1:0] cfg_bypass_o,
  output logic [N_LINES-1:0] cfg_dir_o,
  output logic [N_LINES-1:0] cfg_oe_o
);
  logic [N_LINES-1:0] pin_s;
  logic [N_LINES-1:0] lvl_q, pol_q, any_q, mask_q, stat_clr;
  logic [N_LINES-1:0] pend_w, status_w;

  gpio_irq_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_i),
    .q_o (pin_s)
  );

  gpio_irq_regs #(.N_LINES(N_LINES)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (bus_we),
    .re       (bus_re),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .status   (status_w),
    .pin_s    (pin_s),
    .lvl_q    (lvl_q),
    .pol_q    (pol_q),
    .any_q    (any_q),
    .mask_q   (mask_q),
    .byp_q    (cfg_bypass_o),
    .dir_q    (cfg_dir_o),
    .oe_q     (cfg_oe_o),
    .stat_clr (stat_clr),
    .rdata    (bus_rdata),
    .rvalid   (bus_rvalid)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    gpio_irq_detect u_det (
      .clk      (clk),
      .rst      (rst),
      .pin_s    (pin_s[i]),
      .lvl_mode (lvl_q[i]),
      .pol      (pol_q[i]),
      .any_edge (any_q[i]),
      .clr      (stat_clr[i]),
      .pend_o   (pend_w[i]),
      .status_o (status_w[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(status_w & ~mask_q);
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int N_LINES = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_we,
  input logic [REG_AW-1:0]  bus_addr,
  input logic [N_LINES-1:0] bus_wdata,
  input logic               irq_o,
  input logic [N_LINES-1:0] mask,
  input logic [N_LINES-1:0] status,
  input logic [N_LINES-1:0] pend
);
  logic past_rst_q = 1'b0;

  always_ff @(posedge clk) begin
    past_rst_q <= rst;
    if (past_rst_q) begin
      p_reset_state_r1: assert (mask == '1 && irq_o == 1'b0 && pend == '0);
    end
  end

  p_mask_set_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_MSET) |=> ((mask & $past(bus_wdata)) == $past(bus_wdata)));

  p_mask_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && (bus_addr == A_MSET || bus_addr == A_MCLR)) |=> $stable(mask));

  p_mask_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_MCLR) |=> ((mask & $past(bus_wdata)) == '0));

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == A_STAT) |=> (($past(pend) & ~pend) == '0));

  p_irq_follow_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|(status & ~mask))));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N_LINES(N_LINES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_o     (irq_o),
  .mask      (mask_q),
  .status    (status_w),
  .pend      (pend_w)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pin = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [3:0]    addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata, byp, dir, oe;
  logic          rvalid, irq;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  gpio_irq_ctrl #(.N_LINES(N)) u_dut (
    .clk(clk), .rst(rst), .pin_i(pin),
    .bus_we(we), .bus_re(re), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .bus_rvalid(rvalid), .irq_o(irq),
    .cfg_bypass_o(byp), .cfg_dir_o(dir), .cfg_oe_o(oe)
  );

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (rvalid) begin
      if (sb_q.size() == 0) check("SB unexpected read", rdata, 'x);
      else begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, rdata, it.exp);
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [N-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_exp(logic [3:0] a, logic [N-1:0] e, string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    re = 1'b1; addr = a;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic set_pin(int i, logic v);
    @(negedge clk);
    pin[i] = v;
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {15'b0, irq}, '0);
    check("R1 bypass", byp, '0);
    rd_exp(4'd3, 16'hFFFF, "R1 mask");
    rd_exp(4'd0, 16'h0000, "R1 level");
    rd_exp(4'd5, 16'h0000, "R1 status");

    // R2 / R3 mask strobes
    wr(4'd4, 16'h00FF);
    rd_exp(4'd4, 16'hFF00, "R3 mask clear");
    wr(4'd3, 16'h0003);
    rd_exp(4'd3, 16'hFF03, "R2 mask set");
    wr(4'd4, 16'h0003);
    wr(4'd3, 16'h0000);
    rd_exp(4'd3, 16'hFF00, "R2 zero bits keep");

    // configuration: line0 rise, line1 fall, line2 any edge, line3 level high
    wr(4'd1, 16'h000D);
    wr(4'd2, 16'h0004);
    wr(4'd0, 16'h0008);
    rd_exp(4'd1, 16'h000D, "R4 pol readback");
    rd_exp(4'd5, 16'h0000, "R6 idle status");

    // R4 rising edge, sticky
    set_pin(0, 1'b1);
    rd_exp(4'd5, 16'h0001, "R4 rise pending");
    check("R8 irq on pending", {15'b0, irq}, 16'h0001);
    set_pin(0, 1'b0);
    rd_exp(4'd5, 16'h0001, "R7 sticky after fall");
    wr(4'd5, 16'h0000);
    rd_exp(4'd5, 16'h0001, "R7 zero write keeps");
    wr(4'd5, 16'h0001);
    settle();
    rd_exp(4'd5, 16'h0000, "R7 w1c clears");
    check("R8 irq drops", {15'b0, irq}, '0);

    // R4 falling polarity ignores rise
    set_pin(1, 1'b1);
    rd_exp(4'd5, 16'h0000, "R4 rise ignored pol0");
    set_pin(1, 1'b0);
    rd_exp(4'd5, 16'h0002, "R4 fall pending");
    wr(4'd5, 16'h0002);

    // R5 both edges
    set_pin(2, 1'b1);
    rd_exp(4'd5, 16'h0004, "R5 rise");
    wr(4'd5, 16'h0004);
    set_pin(2, 1'b0);
    rd_exp(4'd5, 16'h0004, "R5 fall");
    wr(4'd5, 16'h0004);
    settle();
    rd_exp(4'd5, 16'h0000, "R5 cleared");

    // R6 level mode
    set_pin(3, 1'b1);
    rd_exp(4'd5, 16'h0008, "R6 level active");
    check("R8 level irq", {15'b0, irq}, 16'h0001);
    wr(4'd5, 16'h0008);
    rd_exp(4'd5, 16'h0008, "R6 w1c no effect");
    set_pin(3, 1'b0);
    rd_exp(4'd5, 16'h0000, "R6 level gone");
    check("R6 irq gone", {15'b0, irq}, '0);

    // R8 masked line pending without irq
    set_pin(8, 1'b1);
    set_pin(8, 1'b0);
    rd_exp(4'd5, 16'h0100, "R8 masked pending");
    check("R8 masked no irq", {15'b0, irq}, '0);
    wr(4'd4, 16'h0100);
    settle();
    check("R8 unmask raises irq", {15'b0, irq}, 16'h0001);
    wr(4'd3, 16'h0100);
    settle();
    check("R8 remask drops irq", {15'b0, irq}, '0);
    wr(4'd5, 16'h0100);

    // R9 pad configuration
    wr(4'd7, 16'h00A5);
    wr(4'd8, 16'hFFFF);
    wr(4'd9, 16'h0F00);
    rd_exp(4'd7, 16'h00A5, "R9 bypass read");
    rd_exp(4'd9, 16'h0F00, "R9 oe read");
    check("R9 bypass out", byp, 16'h00A5);
    check("R9 dir out", dir, 16'hFFFF);
    check("R9 oe out", oe, 16'h0F00);

    // R10 synchroniser delay
    @(negedge clk);
    pin[5] = 1'b1;
    sb_q.push_back('{16'h0000, "R10 not yet visible"});
    re = 1'b1; addr = 4'd6;
    @(negedge clk);
    re = 1'b0;
    settle();
    rd_exp(4'd6, 16'h0020, "R10 visible later");

    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) check("SB drain", 16'(sb_q.size()), '0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule